// File: doc/BRIEF.md
# Reset Controller with Sticky Cause Register

This block merges five reset requests into one system reset for the core and peripherals. The sources are an external active-low pin, the power-on reset, a brown-out detector, a software request and a watchdog timeout. The system reset is released synchronously, a fixed number of cycles after the last request goes away. A second output resets the debug TAP logic. Only a power-on reset drives that output, so debug state survives every other kind of reset.

A six-bit cause register records which sources have fired. Bits build up across successive resets. A power-on reset is the only exception: it wipes the register and leaves only its own indicator set. Software reads the register through a small port. It clears bits by writing zeros to them, and bits written as ones keep their value. The port is closed while the system reset is asserted.

The power-on reset is the block's asynchronous reset `rst_ni`. The brown-out, software and watchdog requests are synchronous to `clk_i` and active high. The pin is asynchronous and is synchronised inside the block.

Top module: `rst_cause_ctrl`

## Requirements
- R1: The system reset is asserted when any of the five sources requests it. A request from brown-out, software or watchdog that is high at a clock edge drives `sys_rst_no` low right after that edge.
- R2: A request from a source sets its cause bit. Bit 0 is the pin, bit 1 power-on, bit 2 brown-out, bit 3 software and bit 4 watchdog. Bit 5 always reads 0.
- R3: Cause bits are sticky. A reset from a source other than power-on never clears a bit that is already set.
- R4: While `rst_ni` is low, both reset outputs are asserted and the cause register holds exactly 6'b000010.
- R5: `tap_rst_no` is asserted only by power-on. The pin, brown-out, software and watchdog sources leave it high.
- R6: The pin passes through a two-flop synchroniser. A low pulse is accepted only if it covers at least `MIN_LOW` clock edges; a shorter pulse affects neither the system reset nor the cause register. An accepted pulse of N edges, starting low before edge c+1, gives a first low sample of `sys_rst_no` after edge c+3+MIN_LOW.
- R7: The system reset stays asserted for exactly `HOLD` cycles after the last cycle in which a request was seen. It then releases on a clock edge.
- R8: A write clears each cause bit written as 0 and leaves each bit written as 1 unchanged. Writing 1 to bit 5 does not make it read 1.
- R9: While `sys_rst_no` is low, reads return 0 and writes are ignored.
- R10: Sources that request in the same cycle all get their bits set. If power-on coincides with other sources, the power-on clear is applied first, and the other sources still requesting after power-on releases then set their bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| bor_i | input | 1 | Brown-out request, active high |
| sw_rst_i | input | 1 | Software reset request, active high |
| wdt_rst_i | input | 1 | Watchdog timeout request, active high |
| rd_en_i | input | 1 | Cause register read enable |
| wr_en_i | input | 1 | Cause register write enable |
| wr_data_i | input | 6 | Write data; a 0 clears the matching bit |
| rd_data_o | output | 6 | Cause bits; zero when not reading or in reset |
| sys_rst_no | output | 1 | Core and peripheral reset, active low |
| tap_rst_no | output | 1 | Debug TAP reset, active low |

## Verification
A synchronous request is registered in the stretch counter at the next edge, so `sys_rst_no` falls after one edge. It stays low for `HOLD` samples after the request drops and is high at the following sample. The pin path adds two synchroniser edges and `MIN_LOW` filter edges before that. The cause register updates on the edge that sees the request, and a register write takes effect at the edge after the write is driven. The driver works out the due cycle of each expected value from these latencies and tags the entry with it. The monitor compares on the falling edge of that exact cycle, so early or late reset edges are caught, not only final states.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int CAUSE_W   = 6;
  localparam int SRC_PIN   = 0;
  localparam int SRC_POR   = 1;
  localparam int SRC_BOR   = 2;
  localparam int SRC_SW    = 3;
  localparam int SRC_WDT   = 4;
  localparam int SRC_RSVD  = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_VALID = 6'b011111;
  localparam logic [CAUSE_W-1:0] CAUSE_POR   = 6'b000010;
endpackage

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
  parameter int MIN_LOW = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic req_o
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_LOW);

  logic [1:0]    sync_q;
  logic          pin_s;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], pin_ni};
  end
  assign pin_s = sync_q[1];

  // count consecutive low samples, saturate at the acceptance level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (pin_s)            cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign req_o = (cnt_q == CNT_MAX);

  p_req_after_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $past(!pin_s));
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int HOLD = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic rst_no
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(HOLD);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= CNT_LOAD;
    else if (req_i)       cnt_q <= CNT_LOAD;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign rst_no = (cnt_q == '0);

  p_enter_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> !rst_no);
  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> !$past(req_i));
endmodule

// File: rtl/rstc_cause_reg.sv
module rstc_cause_reg
  import rstc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CAUSE_W-1:0] set_i,
  input  logic               wr_en_i,
  input  logic [CAUSE_W-1:0] wr_data_i,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [CAUSE_W-1:0] cause_q, kept, cause_d;

  always_comb begin
    kept    = wr_en_i ? (cause_q & wr_data_i) : cause_q;
    cause_d = (kept | set_i) & CAUSE_VALID;  // set wins over clear
  end

  // power-on wipes everything but its own indicator
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= CAUSE_POR;
    else         cause_q <= cause_d;
  end

  assign cause_o = cause_q;

  p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((cause_o & $past(cause_o)) == $past(cause_o)));
  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((cause_o & $past(set_i & CAUSE_VALID)) == $past(set_i & CAUSE_VALID)));
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && set_i == '0) |=>
      (cause_o == ($past(cause_o) & $past(wr_data_i) & CAUSE_VALID)));
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rstc_pkg::*;
#(
  parameter int MIN_LOW = 4,
  parameter int HOLD    = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_rst_ni,
  input  logic               bor_i,
  input  logic               sw_rst_i,
  input  logic               wdt_rst_i,
  input  logic               rd_en_i,
  input  logic               wr_en_i,
  input  logic [CAUSE_W-1:0] wr_data_i,
  output logic [CAUSE_W-1:0] rd_data_o,
  output logic               sys_rst_no,
  output logic               tap_rst_no
);
  logic               pin_req;
  logic               req_any;
  logic [CAUSE_W-1:0] set_vec;
  logic [CAUSE_W-1:0] cause_q;
  logic               wr_ok;

  rstc_pin_filter #(.MIN_LOW(MIN_LOW)) u_pin (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_ni(ext_rst_ni),
    .req_o (pin_req)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[SRC_PIN]  = pin_req;
    set_vec[SRC_BOR]  = bor_i;
    set_vec[SRC_SW]   = sw_rst_i;
    set_vec[SRC_WDT]  = wdt_rst_i;
  end
  assign req_any = |set_vec;

  rstc_stretch #(.HOLD(HOLD)) u_sys_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req_any),
    .rst_no(sys_rst_no)
  );

  // debug domain: only power-on reaches it
  rstc_stretch #(.HOLD(HOLD)) u_tap_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (1'b0),
    .rst_no(tap_rst_no)
  );

  assign wr_ok = wr_en_i & sys_rst_no;

  rstc_cause_reg u_cause (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .wr_en_i  (wr_ok),
    .wr_data_i(wr_data_i),
    .cause_o  (cause_q)
  );

  assign rd_data_o = (rd_en_i && sys_rst_no) ? cause_q : '0;

  p_tap_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_rst_no |=> tap_rst_no);
  p_no_write_in_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_no && wr_en_i) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
  p_rsvd_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> !rd_data_o[SRC_RSVD]);
endmodule

// File: tb/rst_cause_ctrl_tb.sv
module rst_cause_ctrl_tb;
  localparam int MIN_LOW = 4;
  localparam int HOLD    = 8;
  localparam int K_RD  = 0;
  localparam int K_SYS = 1;
  localparam int K_TAP = 2;

  typedef struct {
    int    due;
    int    kind;
    int    exp;
    string tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_n = 1'b1, bor = 1'b0, swr = 1'b0, wdt = 1'b0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [5:0] wr_data = '0;
  logic [5:0] rd_data;
  logic       sys_n, tap_n;

  int    cyc = 0;
  int    n_chk = 0, n_err = 0;
  bit    done = 1'b0;
  item_t sb_q[$];
  logic [5:0] model;

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  rst_cause_ctrl #(.MIN_LOW(MIN_LOW), .HOLD(HOLD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ext_rst_ni(pin_n), .bor_i(bor),
    .sw_rst_i(swr), .wdt_rst_i(wdt), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .sys_rst_no(sys_n),
    .tap_rst_no(tap_n)
  );

  task automatic push(input int d, input int kind, input int exp, input string tag);
    item_t it;
    it.due = cyc + d; it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compares due items on the falling edge
  always @(negedge clk) begin
    for (int i = sb_q.size() - 1; i >= 0; i--) begin
      if (sb_q[i].due == cyc) begin
        int act;
        act = (sb_q[i].kind == K_RD) ? int'(rd_data) :
              (sb_q[i].kind == K_SYS) ? int'(sys_n) : int'(tap_n);
        n_chk++;
        if (act != sb_q[i].exp) begin
          n_err++;
          $display("FAIL %s kind=%0d cyc=%0d actual=%0h expected=%0h",
                   sb_q[i].tag, sb_q[i].kind, cyc, act, sb_q[i].exp);
        end
        sb_q.delete(i);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic read_chk(input string tag);
    rd_en = 1'b1;
    push(1, K_RD, int'(model), tag);
    step(1);
    rd_en = 1'b0;
  endtask

  task automatic write(input logic [5:0] d);
    wr_en = 1'b1; wr_data = d;
    step(1);
    wr_en = 1'b0;
    model = model & d & 6'h1F;
  endtask

  // one-cycle pulse on a synchronous source; checks full stretch window
  task automatic pulse(input int src, input string tag);
    case (src)
      2: bor = 1'b1;
      3: swr = 1'b1;
      default: wdt = 1'b1;
    endcase
    for (int k = 1; k <= HOLD; k++) begin
      push(k, K_SYS, 0, tag);
      push(k, K_TAP, 1, "R5");
    end
    push(HOLD + 1, K_SYS, 1, "R7");
    step(1);
    bor = 1'b0; swr = 1'b0; wdt = 1'b0;
    model[src] = 1'b1;
    step(HOLD + 1);
  endtask

  task automatic pin_pulse(input int n);
    pin_n = 1'b0;
    if (n >= MIN_LOW) begin
      push(2 + MIN_LOW, K_SYS, 1, "R6");
      push(3 + MIN_LOW, K_SYS, 0, "R6");
      push(2 + n + HOLD, K_SYS, 0, "R7");
      push(3 + n + HOLD, K_SYS, 1, "R7");
      push(3 + MIN_LOW, K_TAP, 1, "R5");
      model[0] = 1'b1;
    end else begin
      for (int k = 1; k <= n + HOLD + 4; k++) push(k, K_SYS, 1, "R6");
    end
    step(n);
    pin_n = 1'b1;
    step(n + HOLD + 6);
  endtask

  initial begin
    model = 6'h02;
    step(1);
    push(1, K_SYS, 0, "R4");
    push(1, K_TAP, 0, "R4");
    rd_en = 1'b1;
    push(1, K_RD, 0, "R9");
    step(2);
    rd_en = 1'b0;
    rst_n = 1'b1;
    push(HOLD - 1, K_SYS, 0, "R7");
    push(HOLD - 1, K_TAP, 0, "R4");
    push(HOLD, K_SYS, 1, "R7");
    push(HOLD, K_TAP, 1, "R4");
    step(HOLD + 1);
    read_chk("R4");

    write(6'h3D); read_chk("R8");       // clear power-on bit
    write(6'h20); read_chk("R8");       // reserved stays zero
    pulse(3, "R1"); read_chk("R2");
    pulse(2, "R1"); read_chk("R3");
    pulse(4, "R1"); read_chk("R3");
    pin_pulse(MIN_LOW - 1); read_chk("R6");
    pin_pulse(MIN_LOW);     read_chk("R6");
    write(6'h3B); read_chk("R8");       // clear brown-out only
    write(6'h00); read_chk("R8");

    // simultaneous sources
    bor = 1'b1; wdt = 1'b1;
    step(1);
    bor = 1'b0; wdt = 1'b0;
    model = model | 6'h14;
    step(HOLD + 2);
    read_chk("R10");

    // write during reset is ignored
    swr = 1'b1;
    step(1);
    swr = 1'b0;
    model[3] = 1'b1;
    write(6'h00);
    model = 6'h1C;
    rd_en = 1'b1;
    push(1, K_RD, 0, "R9");
    step(1);
    rd_en = 1'b0;
    step(HOLD + 2);
    read_chk("R9");

    // power-on together with software request
    rst_n = 1'b0; swr = 1'b1;
    step(1);
    push(1, K_TAP, 0, "R4");
    step(2);
    rst_n = 1'b1;
    step(1);
    swr = 1'b0;
    model = 6'h0A;
    step(HOLD + 3);
    read_chk("R10");

    step(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule